// File: doc/BRIEF.md
# ADC Conversion Clock and Sample Strobe Generator

This block derives the conversion clock enable for a multichannel ADC engine from the peripheral clock. The peripheral clock is always halved first. The halved rate then passes through one of two divider chains, chosen by a parameter. The two-stage chain has a programmable prescaler followed by a programmable scaler. The single-stage chain has one wider scaler. The result is a one-cycle enable pulse at the conversion rate.

A converter needs twelve conversion clocks for each sample. The block therefore also raises a one-cycle strobe on every twelfth conversion enable, and the engine uses that strobe to know a result is ready.

The divisor fields are read from a clock-control word. New divisor values take effect only when a full conversion period ends, so a period is never cut short.

Top module: `adc_conv_clk_gen`

## Requirements
- R1: While `rst` is high at a rising edge, all counters clear. `conv_en` and `sample_done` are low for the whole reset and in the first cycle after it.
- R2: With `TWO_STAGE=1`, `conv_en` pulses once every N clocks. N = 2*(P+1)*(S+1), where P = `ctrl_word[31:17]` and S = `ctrl_word[9:0]`.
- R3: With `TWO_STAGE=0`, N = 2*(S+1), where S = `ctrl_word[15:0]`. Bits [31:16] have no effect on either output.
- R4: `conv_en` is high for exactly one clock at a time. After reset it first rises in clock cycle N, counting the first cycle after the last reset edge as cycle 1.
- R5: All divisor fields at zero give the minimum period of two clocks, with no stall: `conv_en` is high on every second clock.
- R6: A divisor change in `ctrl_word` is sampled only at the edge that ends a conversion period, or at a reset edge. A period that is already running keeps its old length.
- R7: `sample_done` is high for one clock, and only together with every twelfth `conv_en` counted since reset.
- R8: With `TWO_STAGE=1`, bits [16:10] of `ctrl_word` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 32 | Clock-control word holding the divisor fields |
| conv_en | output | 1 | One-cycle conversion clock enable |
| sample_done | output | 1 | One-cycle strobe at the end of each twelve-enable sample |

## Verification
Two things can fall in the same clock: the reload of a new divisor and the twelfth enable that raises `sample_done`, because both happen at the end of a conversion period. The bench changes `ctrl_word` at random cycles, so some changes land exactly on an ending period and some land in the middle of one. A cycle-level reference model in the bench recomputes the period and the enable count. Both variants are compared against it on every clock, which shows that the strobe stays aligned and that the new period begins only after the old one completes.

// File: rtl/adc_conv_clk_gen.sv
module adc_conv_clk_gen #(
  parameter bit TWO_STAGE = 1'b1,
  parameter int SAMPLE_CLKS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ctrl_word,
  output logic        conv_en,
  output logic        sample_done
);
  localparam int PW = 15;
  localparam int SW = 16;
  localparam int CW = $clog2(SAMPLE_CLKS);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLE_CLKS - 1);

  logic [PW-1:0] pre_fld, pre_lat, pre_cnt;
  logic [SW-1:0] scl_fld, scl_lat, scl_cnt;
  logic [CW-1:0] smp_cnt;
  logic          half, pre_wrap;

  generate
    if (TWO_STAGE) begin : g_two
      assign pre_fld = ctrl_word[31:17];
      assign scl_fld = {6'd0, ctrl_word[9:0]};
    end else begin : g_one
      assign pre_fld = '0;
      assign scl_fld = ctrl_word[15:0];
    end
  endgenerate

  assign pre_wrap    = half && (pre_cnt == pre_lat);
  assign conv_en     = pre_wrap && (scl_cnt == scl_lat);
  assign sample_done = conv_en && (smp_cnt == SMP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      half    <= 1'b0;
      pre_cnt <= '0;
      scl_cnt <= '0;
      smp_cnt <= '0;
      pre_lat <= pre_fld;
      scl_lat <= scl_fld;
    end else begin
      half <= ~half;
      if (half)
        pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap)
        scl_cnt <= conv_en ? '0 : scl_cnt + 1'b1;
      if (conv_en) begin
        pre_lat <= pre_fld;
        scl_lat <= scl_fld;
        smp_cnt <= (smp_cnt == SMP_LAST) ? '0 : smp_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_conv_clk_gen_chk.sv
module adc_conv_clk_gen_chk (
  input logic clk,
  input logic rst,
  input logic conv_en,
  input logic sample_done
);
  logic [3:0] en_seen;

  always_ff @(posedge clk) begin
    if (rst) en_seen <= '0;
    else if (sample_done) en_seen <= '0;
    else if (conv_en) en_seen <= en_seen + 1'b1;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!conv_en && !sample_done));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    conv_en |=> !conv_en);

  assert_strobe_on_enable_R7: assert property (@(posedge clk) disable iff (rst)
    sample_done |-> conv_en);

  assert_strobe_twelfth_R7: assert property (@(posedge clk) disable iff (rst)
    sample_done |-> (en_seen == 4'd11));

  assert_strobe_not_missed_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_en && en_seen == 4'd11) |-> sample_done);
endmodule

bind adc_conv_clk_gen adc_conv_clk_gen_chk u_chk (
  .clk(clk), .rst(rst), .conv_en(conv_en), .sample_done(sample_done)
);

// File: tb/adc_conv_clk_gen_tb.sv
module adc_conv_clk_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ctrl2 = '0, ctrl1 = '0;
  logic en2, sd2, en1, sd1;
  int vectors = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  adc_conv_clk_gen #(.TWO_STAGE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl2), .conv_en(en2), .sample_done(sd2));
  adc_conv_clk_gen #(.TWO_STAGE(1'b0)) u_dut1 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl1), .conv_en(en1), .sample_done(sd1));

  function automatic int n_two(logic [31:0] w);
    return 2 * (int'(w[31:17]) + 1) * (int'(w[9:0]) + 1);
  endfunction
  function automatic int n_one(logic [31:0] w);
    return 2 * (int'(w[15:0]) + 1);
  endfunction

  int m2 = 0, n2 = 2, k2 = 0, m1 = 0, n1 = 2, k1 = 0;
  always @(posedge clk) begin
    if (rst) begin
      m2 <= 0; n2 <= n_two(ctrl2); k2 <= 0;
      m1 <= 0; n1 <= n_one(ctrl1); k1 <= 0;
    end else begin
      if (m2 == n2 - 1) begin
        m2 <= 0; n2 <= n_two(ctrl2); k2 <= (k2 == 11) ? 0 : k2 + 1;
      end else m2 <= m2 + 1;
      if (m1 == n1 - 1) begin
        m1 <= 0; n1 <= n_one(ctrl1); k1 <= (k1 == 11) ? 0 : k1 + 1;
      end else m1 <= m1 + 1;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cycles, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      begin
        logic e2, e1;
        e2 = !rst && (m2 == n2 - 1);
        e1 = !rst && (m1 == n1 - 1);
        chk(tag, "two-stage conv_en", en2, e2);
        chk(tag == "R3" ? "R3" : "R7", "two-stage sample_done", sd2, e2 && k2 == 11);
        chk(tag == "R8" ? "R3" : tag, "single-stage conv_en", en1, e1);
        chk("R7", "single-stage sample_done", sd1, e1 && k1 == 11);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0A7C));
    tag = "R1";
    ctrl2 = {15'd1, 7'd0, 10'd2};
    ctrl1 = 32'd3;
    step(5);
    @(negedge clk) rst = 1'b0;
    tag = "R4";
    step(80);
    tag = "R5";
    ctrl2 = '0; ctrl1 = '0;
    step(60);
    tag = "R8";
    ctrl2 = {15'd0, 7'h7F, 10'd1};
    ctrl1 = {16'hFFFF, 16'd2};
    step(120);
    for (int seg = 0; seg < 60; seg++) begin
      tag = (seg % 2) ? "R6" : "R2";
      ctrl2 = {15'($urandom % 4), 7'($urandom), 10'($urandom % 6)};
      ctrl1 = {16'($urandom), 16'($urandom % 20)};
      step(30 + $urandom % 300);
    end
    tag = "R1";
    @(negedge clk) rst = 1'b1;
    ctrl2 = {15'd2, 7'd0, 10'd0};
    step(3);
    @(negedge clk) rst = 1'b0;
    tag = "R4";
    step(200);
    tag = "R3";
    ctrl1 = {16'hA5A5, 16'd0};
    step(150);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule